// File: doc/BRIEF.md
# Overcurrent Alarm Conditioner

This block takes one asynchronous overcurrent alarm line from outside the chip and turns it into three clean, clock-domain outputs. The alarm is first corrected for its programmed polarity and brought through a synchronizer. Each new assertion of the corrected alarm is one event, and the events are tallied in a saturating counter.

A sticky interrupt is raised once the tally reaches a programmed threshold. A threshold of zero raises it on every event, and a separate enable suppresses it entirely. An idle timer counts clock cycles in which the alarm is quiet. When that timer reaches its programmed length, it clears the tally and starts counting again from zero.

A throttle request follows the synchronized alarm and stays asserted for a programmed number of microseconds after the alarm goes away. The microsecond is defined by a programmed clocks-per-microsecond value. Whatever consumes the throttle request, and whatever register bus supplies the configuration, sit outside this block.

Top module: `oc_alarm_cond`

## Requirements
- R1: With `cfg_active_low`=0 the alarm is active when `alarm_in` is 1; with `cfg_active_low`=1 it is active when `alarm_in` is 0. Holding `alarm_in` at its idle level produces no event and no throttle request.
- R2: After `alarm_in` becomes active, `throttle_req` is still low following the first rising clock edge and is high following the second.
- R3: `event_count` increments by one on each inactive-to-active transition of the synchronized alarm and saturates at 2^CNT_W-1.
- R4: With `cfg_irq_en`=1 and a nonzero `cfg_threshold`, `irq` is set by an event that brings `event_count` to a value greater than or equal to `cfg_threshold`.
- R5: With `cfg_irq_en`=1 and `cfg_threshold`=0, every event sets `irq`.
- R6: With `cfg_irq_en`=0, no event sets `irq`.
- R7: `irq` stays set until a cycle with `irq_clear`=1 clears it; an event that sets `irq` in the same cycle wins over the clear.
- R8: With a nonzero `cfg_filter`, `event_count` returns to 0 after `cfg_filter` consecutive clock cycles with the synchronized alarm inactive, and the idle timer then restarts. `cfg_filter`=0 disables this clearing.
- R9: After `alarm_in` leaves its active level, `throttle_req` stays high for exactly 2 + H*C rising clock edges, where H is `cfg_hold_us` and C is `cfg_clk_per_us` (a value of 0 for C is taken as 1).
- R10: After reset, with the alarm at its idle level, `event_count` is 0, `irq` is 0 and `throttle_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_in | input | 1 | Asynchronous overcurrent alarm line |
| cfg_active_low | input | 1 | 1: alarm is active low, 0: active high |
| cfg_irq_en | input | 1 | Enables the threshold interrupt |
| cfg_threshold | input | CNT_W | Event count at which the interrupt fires (0: every event) |
| cfg_filter | input | FILT_W | Quiet cycles before the count is cleared (0: never cleared) |
| cfg_clk_per_us | input | PRE_W | Clock cycles per microsecond (0 treated as 1) |
| cfg_hold_us | input | HOLD_W | Throttle hold time after deassertion, in microseconds |
| irq_clear | input | 1 | Write-one-to-clear strobe for the interrupt |
| throttle_req | output | 1 | Throttle request |
| irq | output | 1 | Sticky threshold interrupt |
| event_count | output | CNT_W | Current event count |

## Verification
On every cycle, the assertions check that the count moves only by one step up or back to zero. They also check that a drop to zero comes only after a quiet alarm, and that the interrupt is sticky and is not raised while it is disabled. For the throttle request, they check that it is held as soon as a timed hold starts and that the microsecond count stays nonzero while the hold runs. The exact hold length in cycles for each combination of hold time and prescale, and the exact threshold at which the interrupt appears under both polarities, are shown only by the bench's sweeps. The same goes for the filter expiry point and the saturation value.

// File: rtl/oc_alarm_pkg.sv
// Shared types and helpers for the overcurrent alarm conditioner.
// Assumes nothing beyond IEEE 1800-2017 packages.
package oc_alarm_pkg;

    // Throttle hold sequencer states
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hold_state_e;

    // Saturating increment of an unsigned value of width w held in 32 bits
    function automatic int unsigned sat_inc(input int unsigned val, input int unsigned w);
        int unsigned top;
        top = (32'd1 << w) - 32'd1;
        return (val >= top) ? top : val + 32'd1;
    endfunction

endpackage

// File: rtl/oc_alarm_sync.sv
// Polarity correction and synchronizer for the external alarm line.
// Produces the corrected alarm level, its one-cycle delayed copy and
// one-cycle rise/fall pulses. Assumes STAGES >= 2 and that
// cfg_active_low is stable around reset (it sets the idle reset value).
module oc_alarm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_in,
    input  logic cfg_active_low,
    output logic active,
    output logic active_q,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer, reset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{cfg_active_low}};
        else        chain <= {chain[STAGES-2:0], alarm_in};
    end

    // Polarity-correct the synchronized level
    always_comb active = chain[STAGES-1] ^ cfg_active_low;

    // Keep one cycle of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // Edge pulses of the corrected alarm
    always_comb begin
        rise = active & ~active_q;
        fall = ~active & active_q;
    end

endmodule

// File: rtl/oc_event_counter.sv
// Event tally with threshold interrupt and idle-expiry clearing.
// Counts rise pulses (saturating), raises a sticky irq when the tally
// reaches the threshold, and clears the tally after cfg_filter quiet
// cycles. Assumes rise is a single-cycle pulse coincident with active.
module oc_event_counter
    import oc_alarm_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int FILT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic              irq_clear,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);

    logic [FILT_W-1:0] idle_cnt;
    logic [CNT_W-1:0]  count_next;
    logic              filt_on;
    logic              expire;
    logic              hit;

    // Next tally value, held at the top once full
    always_comb count_next = CNT_W'(sat_inc(32'(count), CNT_W));

    // Idle-expiry and threshold decisions
    always_comb begin
        filt_on = (cfg_filter != '0);
        expire  = filt_on && !active && (idle_cnt == cfg_filter - 1'b1);
        hit     = rise && cfg_irq_en &&
                  ((cfg_threshold == '0) || (count_next >= cfg_threshold));
    end

    // Event tally: step on an event, clear on idle expiry
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (rise)   count <= count_next;
        else if (expire) count <= '0;
    end

    // Quiet-period timer: runs while inactive, rearms on expiry or activity
    always_ff @(posedge clk) begin
        if (!rst_n)                      idle_cnt <= '0;
        else if (active || !filt_on)     idle_cnt <= '0;
        else if (expire)                 idle_cnt <= '0;
        else                             idle_cnt <= idle_cnt + 1'b1;
    end

    // Sticky interrupt, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (hit)       irq <= 1'b1;
        else if (irq_clear) irq <= 1'b0;
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ((count == '0) || (count == CNT_W'($past(count) + 1'b1))));

    // R8
    clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && ($past(count) != '0)) |-> ($past(!active) && $past(cfg_filter != '0)));

    // R6
    irq_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_en && !irq) |=> !irq);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

endmodule

// File: rtl/oc_throttle_hold.sv
// Throttle request with a timed hold after the alarm deasserts.
// A prescaler divides the clock into microseconds (0 treated as 1);
// the hold runs cfg_hold_us of them, starting on the fall pulse.
// Assumes the configuration is stable while a hold is running.
module oc_throttle_hold
    import oc_alarm_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              active_q,
    input  logic              fall,
    input  logic [PRE_W-1:0]  cfg_clk_per_us,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    output logic              throttle_req
);

    hold_state_e       state;
    logic [PRE_W-1:0]  pre;
    logic [PRE_W-1:0]  pre_last;
    logic [HOLD_W-1:0] us_left;
    logic              tick;

    // Last prescaler value of one microsecond
    always_comb begin
        pre_last = (cfg_clk_per_us == '0) ? '0 : cfg_clk_per_us - 1'b1;
        tick     = (pre == pre_last);
    end

    // Hold sequencer: start on fall, count microseconds, cancel on activity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HS_IDLE;
            pre     <= '0;
            us_left <= '0;
        end else if (active) begin
            state   <= HS_IDLE;
            pre     <= '0;
            us_left <= '0;
        end else if (fall) begin
            pre <= '0;
            if (cfg_hold_us != '0) begin
                state   <= HS_HOLD;
                us_left <= cfg_hold_us;
            end
        end else if (state == HS_HOLD) begin
            if (tick) begin
                pre     <= '0;
                us_left <= us_left - 1'b1;
                if (us_left == HOLD_W'(1)) state <= HS_IDLE;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // Request covers the live alarm, its edge cycle and the hold window
    always_comb throttle_req = active | active_q | (state == HS_HOLD);

    // R9
    hold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && (cfg_hold_us != '0)) |=> throttle_req);

    // R9
    us_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_HOLD) |-> (us_left != '0));

endmodule

// File: rtl/oc_alarm_cond.sv
// Top of the overcurrent alarm conditioner: synchronizer, event
// counter with interrupt, and throttle hold timer. Assumes the
// configuration inputs are quasi-static and set before reset release.
module oc_alarm_cond #(
    parameter int CNT_W   = 4,
    parameter int FILT_W  = 16,
    parameter int PRE_W   = 8,
    parameter int HOLD_W  = 8,
    parameter int SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_in,
    input  logic              cfg_active_low,
    input  logic              cfg_irq_en,
    input  logic [CNT_W-1:0]  cfg_threshold,
    input  logic [FILT_W-1:0] cfg_filter,
    input  logic [PRE_W-1:0]  cfg_clk_per_us,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic              irq_clear,
    output logic              throttle_req,
    output logic              irq,
    output logic [CNT_W-1:0]  event_count
);

    logic active, active_q, rise, fall;

    oc_alarm_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .alarm_in       (alarm_in),
        .cfg_active_low (cfg_active_low),
        .active         (active),
        .active_q       (active_q),
        .rise           (rise),
        .fall           (fall)
    );

    oc_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .rise          (rise),
        .cfg_irq_en    (cfg_irq_en),
        .cfg_threshold (cfg_threshold),
        .cfg_filter    (cfg_filter),
        .irq_clear     (irq_clear),
        .count         (event_count),
        .irq           (irq)
    );

    oc_throttle_hold #(.PRE_W(PRE_W), .HOLD_W(HOLD_W)) u_hold (
        .clk            (clk),
        .rst_n          (rst_n),
        .active         (active),
        .active_q       (active_q),
        .fall           (fall),
        .cfg_clk_per_us (cfg_clk_per_us),
        .cfg_hold_us    (cfg_hold_us),
        .throttle_req   (throttle_req)
    );

endmodule

// File: tb/oc_alarm_cond_test.sv
module oc_alarm_cond_test;

    localparam int CNT_W = 4, FILT_W = 16, PRE_W = 8, HOLD_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alarm_in = 1'b0;
    logic              cfg_active_low = 1'b0;
    logic              cfg_irq_en = 1'b0;
    logic [CNT_W-1:0]  cfg_threshold = '0;
    logic [FILT_W-1:0] cfg_filter = '0;
    logic [PRE_W-1:0]  cfg_clk_per_us = '0;
    logic [HOLD_W-1:0] cfg_hold_us = '0;
    logic              irq_clear = 1'b0;
    logic              throttle_req;
    logic              irq;
    logic [CNT_W-1:0]  event_count;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    oc_alarm_cond #(.CNT_W(CNT_W), .FILT_W(FILT_W), .PRE_W(PRE_W), .HOLD_W(HOLD_W)) uut (
        .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in),
        .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
        .cfg_threshold(cfg_threshold), .cfg_filter(cfg_filter),
        .cfg_clk_per_us(cfg_clk_per_us), .cfg_hold_us(cfg_hold_us),
        .irq_clear(irq_clear), .throttle_req(throttle_req),
        .irq(irq), .event_count(event_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        alarm_in = cfg_active_low;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse();
        alarm_in = ~cfg_active_low;
        repeat (3) @(negedge clk);
        alarm_in = cfg_active_low;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10 reset state, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            cfg_active_low = pol[0];
            do_reset();
            repeat (5) @(negedge clk);
            check(event_count == 0, "R10 count", int'(event_count), 0);
            check(irq == 0, "R10 irq", int'(irq), 0);
            check(throttle_req == 0, "R10/R1 throttle idle", int'(throttle_req), 0);
        end

        // R2 synchronizer latency
        cfg_active_low = 1'b0;
        do_reset();
        alarm_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check(throttle_req == 0, "R2 after first edge", int'(throttle_req), 0);
        @(posedge clk); @(negedge clk);
        check(throttle_req == 1, "R2 after second edge", int'(throttle_req), 1);
        alarm_in = 1'b0;
        repeat (5) @(negedge clk);

        // R1 R3 R4 R5 threshold sweep under both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int thr = 0; thr < 5; thr++) begin
                cfg_active_low = pol[0];
                cfg_irq_en = 1'b1;
                cfg_threshold = CNT_W'(thr);
                cfg_filter = '0;
                do_reset();
                for (int n = 1; n <= 5; n++) begin
                    int lim;
                    pulse();
                    lim = (thr == 0) ? 1 : thr;
                    check(event_count == CNT_W'(n), "R3/R1 count", int'(event_count), n);
                    check(irq == (n >= lim), (thr == 0) ? "R5 irq" : "R4 irq",
                          int'(irq), int'(n >= lim));
                end
            end
        end

        // R6 interrupt disabled
        cfg_active_low = 1'b0;
        cfg_irq_en = 1'b0;
        cfg_threshold = CNT_W'(2);
        do_reset();
        for (int n = 0; n < 5; n++) pulse();
        check(irq == 0, "R6 disabled irq", int'(irq), 0);
        check(event_count == 5, "R6 still counts", int'(event_count), 5);

        // R7 sticky and clear
        cfg_irq_en = 1'b1;
        cfg_threshold = CNT_W'(1);
        do_reset();
        pulse();
        repeat (10) @(negedge clk);
        check(irq == 1, "R7 sticky", int'(irq), 1);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        @(negedge clk);
        check(irq == 0, "R7 cleared", int'(irq), 0);
        pulse();
        check(irq == 1, "R7 reset after clear", int'(irq), 1);

        // R3 saturation
        do_reset();
        for (int n = 0; n < 18; n++) pulse();
        check(event_count == 15, "R3 saturate", int'(event_count), 15);

        // R8 idle filter expiry
        cfg_filter = FILT_W'(20);
        do_reset();
        for (int n = 0; n < 3; n++) pulse();
        repeat (10) @(negedge clk);
        check(event_count == 3, "R8 before expiry", int'(event_count), 3);
        repeat (20) @(negedge clk);
        check(event_count == 0, "R8 after expiry", int'(event_count), 0);
        pulse();
        check(event_count == 1, "R8 rearmed", int'(event_count), 1);
        cfg_filter = '0;
        do_reset();
        for (int n = 0; n < 3; n++) pulse();
        repeat (200) @(negedge clk);
        check(event_count == 3, "R8 filter off", int'(event_count), 3);

        // R9 hold length sweep
        for (int h = 0; h < 4; h++) begin
            for (int c = 0; c < 4; c++) begin
                int cnt;
                int exp;
                cfg_hold_us = HOLD_W'(h);
                cfg_clk_per_us = PRE_W'(c);
                do_reset();
                alarm_in = 1'b1;
                repeat (5) @(negedge clk);
                alarm_in = 1'b0;
                cnt = 0;
                for (int k = 0; k < 100; k++) begin
                    @(posedge clk); @(negedge clk);
                    if (throttle_req) cnt++;
                    else break;
                end
                exp = 2 + h * ((c == 0) ? 1 : c);
                check(cnt == exp, "R9 hold edges", cnt, exp);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule